// File: doc/BRIEF.md
# Eight-Channel DAC Host Register Bank

This block is the digital register bank that sits between a host parallel bus and an eight-channel, 10-bit voltage DAC. The host drives a mode input, a 3-bit channel address and a data word with a write strobe. With mode low, the write targets a control register. With mode high, it targets the addressed channel's data path. One system control word is shared by all channels. Each channel has its own control word and a pair of staged codes, one for the coarse (main) converter and one for the fine (sub) converter.

Staged codes reach the converter-facing outputs only on a rising edge of the load strobe. Internally every code is held in offset binary, so data written in twos complement is converted on entry by inverting its MSB. The clear level is 10'h000 under offset binary and 10'h200 under twos complement. Data can be loaded as one 10-bit word or as a low byte followed by a second write that carries the top two bits. The outputs are the per-channel main and sub codes, the standby flags, the output-enable flags and the reference-select fields.

Top module: `octal_dac_regs`

## Requirements
- R1: After reset, every channel's main and sub output codes are 10'h200. All standby flags are 1 because system standby resets to 1. All enable flags are 0 and all reference selects are 2'b00.
- R2: A write with mode_sel=0 and wdata[0]=1 loads the control word of channel addr. Its fields are: wdata[1] data target (1=sub), wdata[2] channel awake (0=standby), wdata[3] channel clear request, wdata[5:4] reference select.
- R3: A write with mode_sel=0 and wdata[0]=0 loads the system word. Its fields are: wdata[1] format (1=byte load), wdata[2] coding (1=offset binary, 0=twos complement), wdata[3] powered (1=normal), wdata[4] system standby, wdata[5] system clear. A channel's standby flag is the OR of system standby and the inverse of that channel's awake bit.
- R4: In word-load format, a write with mode_sel=1 stages wdata into the main code of channel addr when that channel's target bit is 0, and into its sub code when the bit is 1.
- R5: With offset binary selected, data is staged unchanged. With twos complement selected, data is staged with bit 9 inverted.
- R6: The main and sub outputs change only at the clock edge that first samples load_strobe high after it was low (system clear excepted). Holding the strobe high copies nothing further.
- R7: In byte-load format, the first data write supplies bits 7:0. The second supplies bits 9:8 on wdata[2:1] and picks the target with wdata[0] (1=sub), and only the second write changes any staged code. Any system-word write restarts the byte pair.
- R8: While system clear is 1, every channel's main code (output and staged) is forced to the clear level of the current coding, and all sub codes are left unchanged.
- R9: A channel clear request has no effect until the next load strobe edge. At that edge only that channel's main code (output and staged) becomes the clear level, the request bit returns to 0, and the sub code loads normally.
- R10: While powered is 0, every enable flag is 0. Data writes and load strobes still update the codes. When powered is 1, a channel's enable flag is the inverse of its standby flag.
- R11: Each channel's reference-select output equals bits 5:4 of the last control word written to that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| mode_sel | input | 1 | 0 = control write, 1 = data write |
| addr | input | 3 | Channel index |
| wdata | input | 10 | Bus data |
| load_strobe | input | 1 | Load strobe, acts on its rising edge |
| main_code | output | 80 | Main codes, channel i at bits [10i+9:10i], offset binary |
| sub_code | output | 80 | Sub codes, same packing |
| ch_standby | output | 8 | Per-channel standby flag |
| ch_enable | output | 8 | Per-channel output enable |
| ref_sel | output | 16 | Per-channel reference select, channel i at [2i+1:2i] |

## Verification
The main function is swept over all eight channels with distinct main and sub values per channel. A wrong address decode or swapped main/sub routing therefore shows up as a mismatch on a specific channel. The same sweep runs under offset binary with values spread across the range, and under twos complement with the boundary values 000, 1FF, 200 and 3FF, so a missing or misplaced MSB inversion is caught. Byte-pair loads are checked after the first write alone and again after the pair completes, which separates early updates from correct assembly. Clear behaviour is checked under both codings and for a single channel next to untouched neighbours, so the coding-dependent level and the scope of each clear are confirmed independently.

// File: rtl/octal_dac_pkg.sv
// Shared types for the eight-channel DAC register bank.
// Assumes the bus data word is at least 8 bits wide. The packed field order
// of each struct matches the bit order of the bus word it is loaded from.
package octal_dac_pkg;

    // System word, loaded from wdata[5:1]
    typedef struct packed {
        logic sys_clear;
        logic sys_standby;
        logic powered;
        logic coding_offset;
        logic fmt_byte;
    } sys_word_t;

    // Channel word, loaded from wdata[5:1]
    typedef struct packed {
        logic [1:0] ref_sel;
        logic       clr_req;
        logic       awake;
        logic       tgt_sub;
    } ch_word_t;

    localparam sys_word_t SYS_RESET = '{sys_clear: 1'b0, sys_standby: 1'b1,
                                       powered: 1'b1, coding_offset: 1'b0,
                                       fmt_byte: 1'b0};
    localparam ch_word_t  CH_RESET  = '{ref_sel: 2'b00, clr_req: 1'b0,
                                       awake: 1'b1, tgt_sub: 1'b0};

    localparam int unsigned TARGET_BIT = 0;  // 0 = system word, 1 = channel word
    localparam int unsigned FIELD_LO   = 1;
    localparam int unsigned FIELD_HI   = 5;

endpackage

// File: rtl/dac_sys_ctrl.sv
// Shared front end: holds the system word, assembles data words (word or
// byte-pair format), converts them to offset binary and detects the load
// strobe's rising edge. Assumes CODE_W is greater than 8 so that byte mode has
// at least one high bit.
module dac_sys_ctrl
    import octal_dac_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              mode_sel,
    input  logic [CODE_W-1:0] wdata,
    input  logic              load_strobe,
    output sys_word_t         sys_q,
    output logic              data_we,
    output logic [CODE_W-1:0] data_word,
    output logic              route_fixed,
    output logic              route_sub,
    output logic              load_edge,
    output logic [CODE_W-1:0] clr_level
);
    localparam int HI_W = CODE_W - 8;
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    logic       sys_we;
    logic       hi_phase;
    logic [7:0] low_q;
    logic       strobe_q;
    logic [CODE_W-1:0] raw_word;

    assign sys_we = wr_en & ~mode_sel & ~wdata[TARGET_BIT];

    // Holds the shared system word
    always_ff @(posedge clk) begin
        if (!rst_n)      sys_q <= SYS_RESET;
        else if (sys_we) sys_q <= sys_word_t'(wdata[FIELD_HI:FIELD_LO]);
    end

    // Tracks which half of a byte pair comes next and keeps the low byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_phase <= 1'b0;
            low_q    <= '0;
        end else if (sys_we) begin
            hi_phase <= 1'b0;
        end else if (wr_en && mode_sel && sys_q.fmt_byte) begin
            if (!hi_phase) low_q <= wdata[7:0];
            hi_phase <= ~hi_phase;
        end
    end

    // Delays the load strobe for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= load_strobe;
    end

    // Forms the staged word and its routing
    always_comb begin
        raw_word    = sys_q.fmt_byte ? {wdata[HI_W:1], low_q} : wdata;
        data_word   = sys_q.coding_offset ? raw_word : (raw_word ^ MID);
        data_we     = wr_en & mode_sel & (~sys_q.fmt_byte | hi_phase);
        route_fixed = sys_q.fmt_byte;
        route_sub   = wdata[0];
        load_edge   = load_strobe & ~strobe_q;
        clr_level   = sys_q.coding_offset ? '0 : MID;
    end

    p_edge_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_edge |=> !load_edge);
    p_pair_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_we |=> !hi_phase);
    p_low_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_sel && sys_q.fmt_byte && !hi_phase) |=> hi_phase);

endmodule

// File: rtl/dac_channel.sv
// One channel: control word, staged main/sub codes and active output codes.
// Assumes the write, data and load-edge strobes arrive already qualified for
// this channel. System clear outranks the load edge, which outranks a data
// write.
module dac_channel
    import octal_dac_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  ch_word_t          ctrl_wdata,
    input  logic              data_we,
    input  logic [CODE_W-1:0] data_word,
    input  logic              route_fixed,
    input  logic              route_sub,
    input  logic              load_edge,
    input  logic              sys_clear,
    input  logic [CODE_W-1:0] clr_level,
    output ch_word_t          ctrl_q,
    output logic [CODE_W-1:0] main_code,
    output logic [CODE_W-1:0] sub_code
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    logic [CODE_W-1:0] stg_main;
    logic [CODE_W-1:0] stg_sub;
    logic              to_sub;

    assign to_sub = route_fixed ? route_sub : ctrl_q.tgt_sub;

    // Holds the channel control word and consumes a clear request on load
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= CH_RESET;
        else if (ctrl_we)   ctrl_q <= ctrl_wdata;
        else if (load_edge) ctrl_q.clr_req <= 1'b0;
    end

    // Staged main code with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)                            stg_main <= MID;
        else if (sys_clear)                    stg_main <= clr_level;
        else if (load_edge && ctrl_q.clr_req)  stg_main <= clr_level;
        else if (data_we && !to_sub)           stg_main <= data_word;
    end

    // Staged sub code, untouched by any clear
    always_ff @(posedge clk) begin
        if (!rst_n)                stg_sub <= MID;
        else if (data_we && to_sub) stg_sub <= data_word;
    end

    // Active codes seen by the converters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_code <= MID;
            sub_code  <= MID;
        end else begin
            if (sys_clear)      main_code <= clr_level;
            else if (load_edge) main_code <= ctrl_q.clr_req ? clr_level : stg_main;
            if (load_edge)      sub_code  <= stg_sub;
        end
    end

    p_main_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_edge && !sys_clear) |=> $stable(main_code));
    p_sub_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_edge |=> $stable(sub_code));
    p_sys_clear_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clear |=> main_code == $past(clr_level));
    p_ch_clear_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_edge && ctrl_q.clr_req && !sys_clear) |=> main_code == $past(clr_level));
    p_clear_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_edge && !ctrl_we) |=> !ctrl_q.clr_req);

endmodule

// File: rtl/octal_dac_regs.sv
// Top of the eight-channel DAC register bank. Decodes mode and address into
// per-channel strobes, instantiates the shared front end and one block per
// channel, and forms the standby, enable and reference-select outputs.
// Assumes one bus write per cycle and a load strobe wider than one clock is
// acceptable (edge detected).
module octal_dac_regs
    import octal_dac_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 10,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     mode_sel,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [CODE_W-1:0]        wdata,
    input  logic                     load_strobe,
    output logic [NUM_CH*CODE_W-1:0] main_code,
    output logic [NUM_CH*CODE_W-1:0] sub_code,
    output logic [NUM_CH-1:0]        ch_standby,
    output logic [NUM_CH-1:0]        ch_enable,
    output logic [NUM_CH*2-1:0]      ref_sel
);
    sys_word_t         sys_q;
    logic              data_we;
    logic [CODE_W-1:0] data_word;
    logic              route_fixed;
    logic              route_sub;
    logic              load_edge;
    logic [CODE_W-1:0] clr_level;
    logic              ch_ctl_we;
    ch_word_t          ch_wdata;

    assign ch_ctl_we = wr_en & ~mode_sel & wdata[TARGET_BIT];
    assign ch_wdata  = ch_word_t'(wdata[FIELD_HI:FIELD_LO]);

    dac_sys_ctrl #(.CODE_W(CODE_W)) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .mode_sel    (mode_sel),
        .wdata       (wdata),
        .load_strobe (load_strobe),
        .sys_q       (sys_q),
        .data_we     (data_we),
        .data_word   (data_word),
        .route_fixed (route_fixed),
        .route_sub   (route_sub),
        .load_edge   (load_edge),
        .clr_level   (clr_level)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ch_word_t ctrl_q;
        logic     hit;

        assign hit = (addr == ADDR_W'(i));

        dac_channel #(.CODE_W(CODE_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctrl_we     (ch_ctl_we & hit),
            .ctrl_wdata  (ch_wdata),
            .data_we     (data_we & hit),
            .data_word   (data_word),
            .route_fixed (route_fixed),
            .route_sub   (route_sub),
            .load_edge   (load_edge),
            .sys_clear   (sys_q.sys_clear),
            .clr_level   (clr_level),
            .ctrl_q      (ctrl_q),
            .main_code   (main_code[i*CODE_W +: CODE_W]),
            .sub_code    (sub_code[i*CODE_W +: CODE_W])
        );

        // Per-channel flags from the shared and channel words
        always_comb begin
            ch_standby[i]    = sys_q.sys_standby | ~ctrl_q.awake;
            ch_enable[i]     = sys_q.powered & ~ch_standby[i];
            ref_sel[i*2 +: 2] = ctrl_q.ref_sel;
        end
    end

    p_powerdown_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_q.powered |-> (ch_enable == '0));
    p_sys_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_q.sys_standby |-> (&ch_standby));

endmodule

// File: tb/tb_octal_dac_regs.sv
`timescale 1ns/1ps
module tb_octal_dac_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        mode_sel = 1'b0;
    logic [2:0]  addr = '0;
    logic [9:0]  wdata = '0;
    logic        load_strobe = 1'b0;
    logic [79:0] main_code, sub_code;
    logic [7:0]  ch_standby, ch_enable;
    logic [15:0] ref_sel;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model state
    logic [9:0] stg_m [8], stg_s [8], act_m [8], act_s [8];
    logic [1:0] m_ref [8];
    logic       m_clr [8], m_awake [8], m_sub [8];
    logic       m_fmt, m_cod, m_pw, m_sst, m_scl;

    always #2 clk = ~clk;

    octal_dac_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mode_sel(mode_sel),
        .addr(addr), .wdata(wdata), .load_strobe(load_strobe),
        .main_code(main_code), .sub_code(sub_code), .ch_standby(ch_standby),
        .ch_enable(ch_enable), .ref_sel(ref_sel)
    );

    function automatic logic [9:0] clr_lvl();
        return m_cod ? 10'h000 : 10'h200;
    endfunction

    task automatic chk(input string req, input string what, input int ch,
                       input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s ch%0d actual=%h expected=%h", req, what, ch, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        for (int c = 0; c < 8; c++) begin
            logic sb;
            sb = m_sst | ~m_awake[c];
            chk(req, "main", c, main_code[c*10 +: 10], act_m[c]);
            chk(req, "sub", c, sub_code[c*10 +: 10], act_s[c]);
            chk(req, "standby", c, {9'd0, ch_standby[c]}, {9'd0, sb});
            chk(req, "enable", c, {9'd0, ch_enable[c]}, {9'd0, m_pw & ~sb});
            chk(req, "ref", c, {8'd0, ref_sel[c*2 +: 2]}, {8'd0, m_ref[c]});
        end
    endtask

    task automatic bus_wr(input logic md, input logic [2:0] a, input logic [9:0] d);
        @(negedge clk);
        wr_en = 1'b1; mode_sel = md; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic apply_sysclr();
        if (m_scl) for (int c = 0; c < 8; c++) begin
            act_m[c] = clr_lvl(); stg_m[c] = clr_lvl();
        end
    endtask

    task automatic sys_wr(input logic fmt, cod, pw, sst, scl);
        bus_wr(1'b0, 3'd0, {4'd0, scl, sst, pw, cod, fmt, 1'b0});
        m_fmt = fmt; m_cod = cod; m_pw = pw; m_sst = sst; m_scl = scl;
        apply_sysclr();
    endtask

    task automatic ch_wr(input int c, input logic [1:0] rf, input logic clr,
                         input logic awake, input logic sub);
        bus_wr(1'b0, 3'(c), {4'd0, rf, clr, awake, sub, 1'b1});
        m_ref[c] = rf; m_clr[c] = clr; m_awake[c] = awake; m_sub[c] = sub;
    endtask

    task automatic stage(input int c, input logic sub, input logic [9:0] v);
        logic [9:0] w;
        w = m_cod ? v : (v ^ 10'h200);
        if (sub) stg_s[c] = w;
        else if (!m_scl) stg_m[c] = w;
    endtask

    task automatic dat10(input int c, input logic [9:0] v);
        bus_wr(1'b1, 3'(c), v);
        stage(c, m_sub[c], v);
    endtask

    task automatic dat_byte(input int c, input logic sub, input logic [9:0] v);
        bus_wr(1'b1, 3'(c), {2'b00, v[7:0]});
        bus_wr(1'b1, 3'(c), {7'd0, v[9:8], sub});
        stage(c, sub, v);
    endtask

    task automatic model_load();
        for (int c = 0; c < 8; c++) begin
            if (m_scl) act_m[c] = clr_lvl();
            else if (m_clr[c]) begin act_m[c] = clr_lvl(); stg_m[c] = clr_lvl(); end
            else act_m[c] = stg_m[c];
            act_s[c] = stg_s[c];
            m_clr[c] = 1'b0;
        end
    endtask

    task automatic load();
        @(negedge clk); load_strobe = 1'b1;
        @(negedge clk); load_strobe = 1'b0;
        model_load();
    endtask

    initial begin
        for (int c = 0; c < 8; c++) begin
            stg_m[c] = 10'h200; stg_s[c] = 10'h200; act_m[c] = 10'h200; act_s[c] = 10'h200;
            m_ref[c] = 2'b00; m_clr[c] = 1'b0; m_awake[c] = 1'b1; m_sub[c] = 1'b0;
        end
        m_fmt = 0; m_cod = 0; m_pw = 1; m_sst = 1; m_scl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R3 system word, R2/R11 channel words
        sys_wr(0, 1, 1, 0, 0);
        for (int c = 0; c < 8; c++) ch_wr(c, 2'(c % 4), 1'b0, 1'b1, 1'b0);
        check_all("R2_R3_R11");

        // R4 main/sub routing sweep, R6 nothing moves before strobe
        for (int c = 0; c < 8; c++) dat10(c, 10'(c * 97 + 5));
        for (int c = 0; c < 8; c++) ch_wr(c, 2'(3 - c % 4), 1'b0, 1'b1, 1'b1);
        for (int c = 0; c < 8; c++) dat10(c, 10'(c * 61 + 300));
        check_all("R6");
        load();
        check_all("R4");

        // R5 twos complement boundaries
        sys_wr(0, 0, 1, 0, 0);
        for (int c = 0; c < 8; c++) ch_wr(c, 2'(c % 4), 1'b0, 1'b1, 1'b0);
        dat10(0, 10'h000); dat10(1, 10'h1FF); dat10(2, 10'h200); dat10(3, 10'h3FF);
        dat10(4, 10'h155); dat10(5, 10'h2AA); dat10(6, 10'h001); dat10(7, 10'h3FE);
        load();
        check_all("R5");

        // R6 strobe held high: only the first edge copies
        @(negedge clk); load_strobe = 1'b1;
        model_load();
        bus_wr(1'b1, 3'd2, 10'h0F0);
        stage(2, 1'b0, 10'h0F0);
        check_all("R6");
        @(negedge clk); load_strobe = 1'b0;
        load();
        check_all("R6");

        // R7 byte pair: first half alone changes nothing
        sys_wr(1, 1, 1, 0, 0);
        bus_wr(1'b1, 3'd4, 10'h0A5);
        load();
        check_all("R7");
        bus_wr(1'b1, 3'd4, 10'b0000000_11_0);
        stage(4, 1'b0, 10'h3A5);
        load();
        check_all("R7");
        for (int c = 0; c < 8; c++) dat_byte(c, c[0], 10'(c * 113 + 17));
        load();
        check_all("R7");

        // R8 system clear under both codings
        sys_wr(0, 1, 1, 0, 1);
        check_all("R8");
        sys_wr(0, 0, 1, 0, 1);
        check_all("R8");
        dat10(1, 10'h123);
        load();
        check_all("R8");
        sys_wr(0, 1, 1, 0, 0);
        for (int c = 0; c < 8; c++) dat10(c, 10'(c * 50 + 400));
        load();
        check_all("R8");

        // R9 channel clear waits for strobe and hits one channel
        ch_wr(3, 2'b01, 1'b1, 1'b1, 1'b0);
        dat10(5, 10'h2F0);
        check_all("R9");
        load();
        check_all("R9");
        load();
        check_all("R9");

        // R10 power-down: enables low, data still accepted
        sys_wr(0, 1, 0, 0, 0);
        check_all("R10");
        for (int c = 0; c < 8; c++) dat10(c, 10'(c * 29 + 1));
        load();
        check_all("R10");

        // R3 per-channel standby, R10 enable follows standby
        sys_wr(0, 1, 1, 0, 0);
        ch_wr(5, 2'b10, 1'b0, 1'b0, 1'b0);
        ch_wr(6, 2'b11, 1'b0, 1'b1, 1'b0);
        check_all("R3_R10");
        sys_wr(0, 1, 1, 1, 0);
        check_all("R3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule